// File: doc/BRIEF.md
# Time-Partition Scheduler with Interrupt Holding

This block gives a single processor strict time partitioning across several isolated partitions. A small schedule table lists, in order, which partition runs in each slot and how many clock ticks that slot lasts. Only a trusted-mode write can change the table. While a slot runs, the block counts its budget down. When the budget runs out, the block asks the processor to save the outgoing context. After that is acknowledged, it advances to the next table slot, updates the current-partition register and asks for the incoming context to be loaded. Slots wrap in a fixed rotation over the programmed number of entries.

Each interrupt line has an owning partition. A rising edge on a line is latched as pending for its owner. The block releases pending interrupts only while the owner is the running partition and interrupts are enabled. Interrupts for other partitions stay latched until their owner's next slot. Interrupts are disabled from the moment a budget expires until the incoming load is acknowledged.

Top module: `part_sched`

## Requirements
- R1: After reset the block is in the load phase at slot 0: load_req=1, save_req=0, cur_slot=0, cur_part=0, ints_on=0, ticks_left=0, irq_valid=0. Table entry i resets to partition i (mod 2^PID_W) with RST_BUDGET ticks, and the used-entry count resets to ENTRIES.
- R2: After load_ack, the slot runs for exactly the entry's budget in cycles, or one cycle for a budget of 0. During the run, ticks_left starts at the budget and falls by one per cycle. The cycle after the last run cycle, save_req is 1.
- R3: save_req stays high until save_ack, and load_req stays high until load_ack. The two are never high together. ticks_left holds at 0 throughout the save and load phases.
- R4: On save_ack, cur_slot advances by one, and wraps to 0 when the next index would reach the used-entry count.
- R5: ints_on is 1 exactly in the run phase. It is 0 from budget expiry until load_ack.
- R6: Table and count writes take effect only when cfg_trusted=1. Untrusted writes change neither slot lengths, partition numbers nor rotation.
- R7: A trusted count write of 0 or of more than ENTRIES is ignored.
- R8: A rising edge on a line whose owner (irq_owner bits [l*PID_W +: PID_W]) is not running is held pending. It is delivered in the second cycle after the owner's load_ack.
- R9: A pending line of the running partition is delivered as a one-cycle irq_valid pulse with irq_line=l. Delivery happens two cycles after the edge. Lower line numbers go first, one per cycle, and each edge is delivered once even if the line stays high.
- R10: cur_part takes the next slot's partition number on save_ack, and is re-read from the current slot's entry on load_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_trusted | input | 1 | Write issued in trusted mode |
| cfg_slot | input | IDX_W | Entry index to write |
| cfg_part | input | PID_W | Partition number for the entry |
| cfg_ticks | input | BUD_W | Tick budget for the entry |
| len_we | input | 1 | Used-entry count write strobe |
| len_val | input | IDX_W+1 | New used-entry count |
| save_req | output | 1 | Request to save the outgoing context |
| save_ack | input | 1 | Save done |
| load_req | output | 1 | Request to load the incoming context |
| load_ack | input | 1 | Load done |
| irq_in | input | IRQ_LINES | Interrupt lines |
| irq_owner | input | IRQ_LINES*PID_W | Owning partition of each line |
| cur_part | output | PID_W | Current partition number |
| cur_slot | output | IDX_W | Current table slot |
| ints_on | output | 1 | Interrupts enabled (run phase) |
| ticks_left | output | BUD_W | Remaining budget of the running slot |
| irq_valid | output | 1 | Interrupt delivered this cycle |
| irq_line | output | LINE_W | Line number of the delivered interrupt |

## Verification
A wrong phase or budget register shows up as a slot whose length differs from its table budget: save_req arrives early or late by the error. A wrong slot index or partition register is visible at the save_ack edge, because cur_slot and cur_part change in the same cycle. A corrupted pending bit shows as an irq_valid pulse at the wrong time, at most two cycles after the owner becomes active, or as a missing pulse in that window. The bench therefore checks slot lengths to the cycle, the index and partition after each acknowledge, and the exact delivery cycle of each held interrupt.

// File: rtl/part_sched.sv
module part_sched #(
  parameter int ENTRIES    = 8,
  parameter int PID_W      = 3,
  parameter int BUD_W      = 16,
  parameter int IRQ_LINES  = 4,
  parameter int RST_BUDGET = 16,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int LINE_W = $clog2(IRQ_LINES),
  localparam int NPART  = 1 << PID_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic                       cfg_trusted,
  input  logic [IDX_W-1:0]           cfg_slot,
  input  logic [PID_W-1:0]           cfg_part,
  input  logic [BUD_W-1:0]           cfg_ticks,
  input  logic                       len_we,
  input  logic [IDX_W:0]             len_val,
  output logic                       save_req,
  input  logic                       save_ack,
  output logic                       load_req,
  input  logic                       load_ack,
  input  logic [IRQ_LINES-1:0]       irq_in,
  input  logic [IRQ_LINES*PID_W-1:0] irq_owner,
  output logic [PID_W-1:0]           cur_part,
  output logic [IDX_W-1:0]           cur_slot,
  output logic                       ints_on,
  output logic [BUD_W-1:0]           ticks_left,
  output logic                       irq_valid,
  output logic [LINE_W-1:0]          irq_line
);

  typedef enum logic [1:0] {ST_RUN, ST_SAVE, ST_LOAD} phase_t;

  phase_t                st;
  logic [PID_W-1:0]      tab_pid [ENTRIES];
  logic [BUD_W-1:0]      tab_bud [ENTRIES];
  logic [IDX_W:0]        used;
  logic [IRQ_LINES-1:0]  pend [NPART];
  logic [IRQ_LINES-1:0]  irq_q;
  logic                  hit;
  logic [LINE_W-1:0]     hit_line;
  logic [IDX_W-1:0]      nxt;

  wire                 wr_ok  = cfg_we & cfg_trusted;
  wire                 len_ok = len_we & cfg_trusted & (len_val != '0) &
                                (len_val <= (IDX_W+1)'(ENTRIES));
  wire [IDX_W:0]       inc    = {1'b0, cur_slot} + (IDX_W+1)'(1);
  wire [IRQ_LINES-1:0] rise   = irq_in & ~irq_q;

  assign nxt      = (inc >= used) ? '0 : inc[IDX_W-1:0];
  assign save_req = (st == ST_SAVE);
  assign load_req = (st == ST_LOAD);
  assign ints_on  = (st == ST_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tab_pid[i] <= PID_W'(i);
        tab_bud[i] <= BUD_W'(RST_BUDGET);
      end
      used <= (IDX_W+1)'(ENTRIES);
    end else begin
      if (wr_ok) begin
        tab_pid[cfg_slot] <= cfg_part;
        tab_bud[cfg_slot] <= cfg_ticks;
      end
      if (len_ok) used <= len_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_LOAD;
      cur_slot   <= '0;
      cur_part   <= '0;
      ticks_left <= '0;
    end else begin
      case (st)
        ST_RUN: begin
          if (ticks_left <= BUD_W'(1)) begin
            st         <= ST_SAVE;
            ticks_left <= '0;
          end else begin
            ticks_left <= ticks_left - BUD_W'(1);
          end
        end
        ST_SAVE: if (save_ack) begin
          st       <= ST_LOAD;
          cur_slot <= nxt;
          cur_part <= tab_pid[nxt];
        end
        default: if (load_ack) begin
          st         <= ST_RUN;
          cur_part   <= tab_pid[cur_slot];
          ticks_left <= tab_bud[cur_slot];
        end
      endcase
    end
  end

  always_comb begin
    hit      = 1'b0;
    hit_line = '0;
    for (int l = IRQ_LINES - 1; l >= 0; l--) begin
      if (pend[cur_part][l]) begin
        hit      = ints_on;
        hit_line = LINE_W'(l);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q     <= '0;
      irq_valid <= 1'b0;
      irq_line  <= '0;
      for (int p = 0; p < NPART; p++) pend[p] <= '0;
    end else begin
      irq_q     <= irq_in;
      irq_valid <= hit;
      if (hit) irq_line <= hit_line;
      for (int p = 0; p < NPART; p++) begin
        for (int l = 0; l < IRQ_LINES; l++) begin
          if (rise[l] && irq_owner[l*PID_W +: PID_W] == PID_W'(p))
            pend[p][l] <= 1'b1;
          else if (hit && cur_part == PID_W'(p) && hit_line == LINE_W'(l))
            pend[p][l] <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/part_sched_chk.sv
module part_sched_chk #(
  parameter int BUD_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             save_req,
  input logic             save_ack,
  input logic             load_req,
  input logic             ints_on,
  input logic [BUD_W-1:0] ticks_left,
  input logic             irq_valid
);

  assert_save_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && !save_ack) |=> save_req);

  assert_one_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(save_req && load_req));

  assert_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ints_on && $past(!ints_on)) |-> $stable(ticks_left));

  assert_countdown_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ints_on && $past(ints_on)) |-> (ticks_left == $past(ticks_left) - BUD_W'(1)));

  assert_ints_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req || load_req) |-> !ints_on);

  assert_gated_delivery_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> $past(ints_on));

endmodule

bind part_sched part_sched_chk #(.BUD_W(BUD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .save_req   (save_req),
  .save_ack   (save_ack),
  .load_req   (load_req),
  .ints_on    (ints_on),
  .ticks_left (ticks_left),
  .irq_valid  (irq_valid)
);

// File: tb/part_sched_tb.sv
module part_sched_tb;
  localparam int ENTRIES = 8, PID_W = 3, BUD_W = 16, IRQ_LINES = 4;
  localparam int IDX_W = 3, LINE_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_trusted = 0, len_we = 0;
  logic [IDX_W-1:0] cfg_slot = '0;
  logic [PID_W-1:0] cfg_part = '0;
  logic [BUD_W-1:0] cfg_ticks = '0;
  logic [IDX_W:0] len_val = '0;
  logic save_ack = 0, load_ack = 0;
  logic [IRQ_LINES-1:0] irq_in = '0;
  logic [IRQ_LINES*PID_W-1:0] irq_owner;
  logic save_req, load_req, ints_on, irq_valid;
  logic [PID_W-1:0] cur_part;
  logic [IDX_W-1:0] cur_slot;
  logic [BUD_W-1:0] ticks_left;
  logic [LINE_W-1:0] irq_line;

  int checks = 0, fails = 0;

  // line0 -> part1, line1 -> part1, line2 -> part2, line3 -> part1
  assign irq_owner = {3'd1, 3'd2, 3'd1, 3'd1};

  always #10 clk = ~clk;

  part_sched #(.ENTRIES(ENTRIES), .PID_W(PID_W), .BUD_W(BUD_W),
               .IRQ_LINES(IRQ_LINES), .RST_BUDGET(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_trusted(cfg_trusted),
    .cfg_slot(cfg_slot), .cfg_part(cfg_part), .cfg_ticks(cfg_ticks),
    .len_we(len_we), .len_val(len_val), .save_req(save_req), .save_ack(save_ack),
    .load_req(load_req), .load_ack(load_ack), .irq_in(irq_in), .irq_owner(irq_owner),
    .cur_part(cur_part), .cur_slot(cur_slot), .ints_on(ints_on),
    .ticks_left(ticks_left), .irq_valid(irq_valid), .irq_line(irq_line));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_entry(input bit tr, input int idx, input int pid, input int bud);
    @(negedge clk);
    cfg_we = 1; cfg_trusted = tr; cfg_slot = IDX_W'(idx);
    cfg_part = PID_W'(pid); cfg_ticks = BUD_W'(bud);
    @(negedge clk);
    cfg_we = 0; cfg_trusted = 0;
  endtask

  task automatic wr_len(input bit tr, input int v);
    @(negedge clk);
    len_we = 1; cfg_trusted = tr; len_val = (IDX_W+1)'(v);
    @(negedge clk);
    len_we = 0; cfg_trusted = 0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(load_req == 1 && save_req == 0, "R1 phase", int'(load_req), 1);
    chk(cur_slot == 0 && cur_part == 0, "R1 slot/part", int'(cur_slot), 0);
    chk(ints_on == 0 && irq_valid == 0, "R1 ints", int'(ints_on), 0);
    chk(ticks_left == 0, "R1 ticks", int'(ticks_left), 0);
  endtask

  task automatic do_load(input int eslot, input int epart, input int eticks);
    chk(load_req == 1 && cur_slot == IDX_W'(eslot), "R3 load slot", int'(cur_slot), eslot);
    load_ack = 1;
    @(negedge clk);
    load_ack = 0;
    chk(ints_on == 1, "R5 ints on after load", int'(ints_on), 1);
    chk(cur_part == PID_W'(epart), "R10 part on load", int'(cur_part), epart);
    chk(ticks_left == BUD_W'(eticks), "R2 initial ticks", int'(ticks_left), eticks);
  endtask

  task automatic measure(input int elen);
    int n = 1;
    while (!save_req && n < 1000) begin
      @(negedge clk);
      if (!save_req) n++;
    end
    chk(n == elen, "R2 slot length", n, elen);
    chk(ints_on == 0, "R5 ints off at expiry", int'(ints_on), 0);
  endtask

  task automatic do_save(input int oslot, input int nslot, input int npart);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(save_req == 1 && cur_slot == IDX_W'(oslot) && ticks_left == 0,
          "R3 save hold", int'(save_req), 1);
    end
    save_ack = 1;
    @(negedge clk);
    save_ack = 0;
    chk(cur_slot == IDX_W'(nslot), "R4 next slot", int'(cur_slot), nslot);
    chk(cur_part == PID_W'(npart), "R10 part on save_ack", int'(cur_part), npart);
    chk(load_req == 1 && save_req == 0, "R3 load phase", int'(load_req), 1);
    repeat (2) @(negedge clk);
    chk(load_req == 1 && ticks_left == 0 && ints_on == 0, "R3 frozen in load",
        int'(ticks_left), 0);
  endtask

  task automatic t_program;
    wr_entry(1, 0, 1, 30);
    wr_entry(1, 1, 2, 3);
    wr_entry(1, 2, 3, 0);
    wr_len(1, 3);
    wr_entry(0, 0, 5, 40);   // R6 untrusted, must be ignored
    wr_len(0, 1);            // R6 untrusted, must be ignored
    wr_len(1, 0);            // R7 ignored
    wr_len(1, 9);            // R7 ignored
    @(negedge clk);
  endtask

  task automatic t_rotation;
    do_load(0, 1, 30); measure(30); do_save(0, 1, 2);
    do_load(1, 2, 3);  measure(3);  do_save(1, 2, 3);
    do_load(2, 3, 0);  measure(1);  do_save(2, 0, 1);  // R4 wrap, R6/R7 count kept
  endtask

  task automatic t_irq_current;
    int seen = 0;
    do_load(0, 1, 30);
    irq_in[1] = 1;
    @(negedge clk);
    chk(irq_valid == 0, "R9 not before two cycles", int'(irq_valid), 0);
    @(negedge clk);
    chk(irq_valid == 1 && irq_line == 2'd1, "R9 deliver line1", int'(irq_line), 1);
    @(negedge clk);
    chk(irq_valid == 0, "R9 single delivery", int'(irq_valid), 0);
    irq_in = 4'b1111;
    @(negedge clk);
    @(negedge clk);
    chk(irq_valid == 1 && irq_line == 2'd0, "R9 lowest first", int'(irq_line), 0);
    @(negedge clk);
    chk(irq_valid == 1 && irq_line == 2'd3, "R9 then line3", int'(irq_line), 3);
    while (!save_req && seen < 1000) begin
      @(negedge clk);
      if (irq_valid) seen++;
    end
    chk(seen == 0, "R8 other partition held", seen, 0);
    irq_in = '0;
    do_save(0, 1, 2);
  endtask

  task automatic t_irq_held;
    do_load(1, 2, 3);
    @(negedge clk);
    chk(irq_valid == 1 && irq_line == 2'd2, "R8 deliver on owner load", int'(irq_line), 2);
    @(negedge clk);
    chk(irq_valid == 0, "R8 delivered once", int'(irq_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_program();
    t_rotation();
    t_irq_current();
    t_irq_held();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule